// File: doc/BRIEF.md
# Two-Wire Bus Controller Register File

This block is the host-visible register bank of a two-wire serial bus controller. A host reaches it through a simple synchronous port. The port has separate read and write strobes, a small byte address and a combinational read path. On the other side, the block feeds the controller's bit-level engine with the enable, clock divider, own address and control requests. The engine reports events back to the block as single-cycle pulses and one level. These are a received byte, readiness for the next byte, bus error, negative acknowledge, stall after start, bus busy, completion of START and STOP, and current mastership.

The block decides the host-visible semantics on its own. Error-type status flags are sticky and cleared by writing one. Data-ready follows data-register accesses. START and STOP requests drop by themselves when the engine reports them done. The control register that carries those requests stays locked at zero until the module is enabled.

Top module: `twb_regfile`

## Requirements
- R1: After reset every register reads zero; the status register (offset 1) then shows only the live mastership bit.
- R2: Offsets are data 0, status 1, control-status 2, control 1 at 3, own address 4, control 2 at 5; any other offset reads zero and writes to it change nothing.
- R3: Status bits 5 (bus error), 4 (negative acknowledge) and 3 (stall after start) are sticky; a host write with a one in a bit's position clears it, a zero leaves it unchanged.
- R4: An engine set pulse for one of those three flags wins over a host clear in the same cycle.
- R5: Control-status bit 1 (bus busy) is set by the engine's busy pulse and cleared by a host write with bit 1 set; set wins.
- R6: Control 1 keeps bits 7 (stall enable), 6 (interrupt enable), 4 (ACK control), 1 (STOP) and 0 (START); the others read zero. A write lands only if control 2 bit 0 was already set before that cycle. While that bit is clear, control 1 reads zero, drives zero to the engine, and is emptied.
- R7: Control 2 is a full 8-bit read/write register (0x70 reads back as 0x70); bit 0 drives the engine enable and bits 7:1 drive the clock divider output.
- R8: START (bit 0) and STOP (bit 1) clear on their engine done pulses; a host write to control 1 in the same cycle takes precedence.
- R9: Own address is an 8-bit read/write register driven to the engine; slave matching is enabled exactly when it is nonzero.
- R10: A host write to offset 0 loads the transmit byte; an engine receive pulse loads the received byte and sets data-ready (status bit 6), winning over a simultaneous host write.
- R11: Any host read or write of offset 0 clears data-ready; an engine receive or ready pulse in the same cycle keeps it set.
- R12: Status bit 1 follows the engine's mastership level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | ADDR_W | Host byte offset |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data (combinational) |
| eng_rx_valid | input | 1 | Engine received a byte |
| eng_rx_byte | input | DATA_W | Received byte |
| eng_tx_ready | input | 1 | Engine ready for next byte |
| eng_set_ber | input | 1 | Bus error event |
| eng_set_nack | input | 1 | Negative acknowledge event |
| eng_set_stall | input | 1 | Stall after start event |
| eng_master | input | 1 | Engine currently owns the bus |
| eng_busy_set | input | 1 | Bus became busy |
| eng_start_done | input | 1 | START condition issued |
| eng_stop_done | input | 1 | STOP condition issued |
| eng_enable | output | 1 | Module enable |
| eng_scl_div | output | DATA_W-1 | Clock divider setting |
| eng_tx_byte | output | DATA_W | Data register contents |
| eng_data_ready | output | 1 | Data-ready flag |
| eng_own_addr | output | DATA_W | Own address register |
| eng_slave_en | output | 1 | Slave address matching enabled |
| eng_stall_en | output | 1 | Stall after start enable |
| eng_int_en | output | 1 | Interrupt enable |
| eng_ack_ctl | output | 1 | ACK control |
| eng_start_req | output | 1 | START request |
| eng_stop_req | output | 1 | STOP request |

## Verification
The bench collides engine set pulses with host clears in the same cycle. A design that let the host win would lose a bus error or a busy indication. It also writes control 1 while disabled, in the cycle enable drops and just after re-enabling. A design that gated only the read path would leave a stale START or interrupt enable with the engine, or would show it again after re-enabling. It pairs done pulses with simultaneous control 1 writes, where a wrong priority drops a fresh START. Data-ready is driven against reads, writes and receive pulses, so a flag that stayed set or lost a new byte shows up in the status read.

// File: rtl/twb_pkg.sv
package twb_pkg;
   // register offsets
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_STAT = 1;
   localparam int unsigned OFS_CST  = 2;
   localparam int unsigned OFS_CTL1 = 3;
   localparam int unsigned OFS_OWN  = 4;
   localparam int unsigned OFS_CTL2 = 5;

   // status bit positions
   localparam int unsigned ST_RDY   = 6;
   localparam int unsigned ST_BER   = 5;
   localparam int unsigned ST_NACK  = 4;
   localparam int unsigned ST_STALL = 3;
   localparam int unsigned ST_MAST  = 1;

   // control-status
   localparam int unsigned CS_BUSY  = 1;

   // control 1
   localparam int unsigned C1_STALLE = 7;
   localparam int unsigned C1_INTE   = 6;
   localparam int unsigned C1_ACK    = 4;
   localparam int unsigned C1_STOP   = 1;
   localparam int unsigned C1_START  = 0;
   localparam logic [7:0]  C1_MASK   = 8'((1 << C1_STALLE) | (1 << C1_INTE) |
                                          (1 << C1_ACK) | (1 << C1_STOP) |
                                          (1 << C1_START));

   // control 2
   localparam int unsigned C2_EN = 0;

   // sticky flag slots in the flag bank
   localparam int unsigned FL_BER   = 0;
   localparam int unsigned FL_NACK  = 1;
   localparam int unsigned FL_STALL = 2;
   localparam int unsigned FL_BUSY  = 3;
   localparam int unsigned FL_N     = 4;
endpackage

// File: rtl/twb_flag_bank.sv
module twb_flag_bank #(
   parameter int unsigned NFLAG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_i,
   input  logic [NFLAG-1:0] clr_i,
   output logic [NFLAG-1:0] flag_q
);
   generate
      for (genvar g = 0; g < NFLAG; g++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q[g] <= 1'b0;
            else if (set_i[g])
               flag_q[g] <= 1'b1;
            else if (clr_i[g])
               flag_q[g] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/twb_data_reg.sv
module twb_data_reg #(
   parameter int unsigned DATA_W        = 8,
   parameter bit          RDY_CLR_ON_WR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] data_q,
   output logic              ready_q
);
   logic touch;

   generate
      if (RDY_CLR_ON_WR) begin : g_clr_rw
         assign touch = host_rd | host_wr;
      end else begin : g_clr_rd
         assign touch = host_rd;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         ready_q <= 1'b0;
      end else begin
         if (rx_valid)
            data_q <= rx_byte;
         else if (host_wr)
            data_q <= host_wdata;

         if (rx_valid || tx_ready)
            ready_q <= 1'b1;
         else if (touch)
            ready_q <= 1'b0;
      end
   end
endmodule

// File: rtl/twb_ctrl_regs.sv
module twb_ctrl_regs
   import twb_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl1,
   input  logic              wr_own,
   input  logic              wr_ctl2,
   input  logic [DATA_W-1:0] wdata,
   input  logic              start_done,
   input  logic              stop_done,
   output logic [DATA_W-1:0] ctl1_vis,
   output logic [DATA_W-1:0] own_q,
   output logic [DATA_W-1:0] ctl2_q
);
   localparam logic [DATA_W-1:0] MASK = DATA_W'(C1_MASK);

   logic [DATA_W-1:0] ctl1_q;
   logic              en;

   assign en = ctl2_q[C2_EN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl2_q <= '0;
         own_q  <= '0;
      end else begin
         if (wr_ctl2) ctl2_q <= wdata;
         if (wr_own)  own_q  <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         ctl1_q <= '0;
      end else if (wr_ctl1) begin
         ctl1_q <= wdata & MASK;
      end else begin
         if (start_done) ctl1_q[C1_START] <= 1'b0;
         if (stop_done)  ctl1_q[C1_STOP]  <= 1'b0;
      end
   end

   assign ctl1_vis = en ? ctl1_q : '0;
endmodule

// File: rtl/twb_regfile.sv
module twb_regfile
   import twb_pkg::*;
#(
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned DATA_W        = 8,
   parameter bit          RDY_CLR_ON_WR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_wr,
   input  logic              hst_rd,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [DATA_W-1:0] hst_wdata,
   output logic [DATA_W-1:0] hst_rdata,
   input  logic              eng_rx_valid,
   input  logic [DATA_W-1:0] eng_rx_byte,
   input  logic              eng_tx_ready,
   input  logic              eng_set_ber,
   input  logic              eng_set_nack,
   input  logic              eng_set_stall,
   input  logic              eng_master,
   input  logic              eng_busy_set,
   input  logic              eng_start_done,
   input  logic              eng_stop_done,
   output logic              eng_enable,
   output logic [DATA_W-2:0] eng_scl_div,
   output logic [DATA_W-1:0] eng_tx_byte,
   output logic              eng_data_ready,
   output logic [DATA_W-1:0] eng_own_addr,
   output logic              eng_slave_en,
   output logic              eng_stall_en,
   output logic              eng_int_en,
   output logic              eng_ack_ctl,
   output logic              eng_start_req,
   output logic              eng_stop_req
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("twb_regfile: ADDR_W must be at least 3");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("twb_regfile: field layout needs DATA_W of 8");
      end
   endgenerate

   localparam int unsigned NREG = 6;

   logic [NREG-1:0]   wsel, rsel;
   logic [FL_N-1:0]   fl_set, fl_clr, fl_q;
   logic [DATA_W-1:0] data_q, ctl1_vis, own_q, ctl2_q;
   logic [DATA_W-1:0] sts_vec, cst_vec;
   logic              rdy_q;

   generate
      for (genvar k = 0; k < NREG; k++) begin : g_dec
         assign wsel[k] = hst_wr && (hst_addr == ADDR_W'(k));
         assign rsel[k] = hst_rd && (hst_addr == ADDR_W'(k));
      end
   endgenerate

   twb_data_reg #(.DATA_W(DATA_W), .RDY_CLR_ON_WR(RDY_CLR_ON_WR)) i_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (wsel[OFS_DATA]),
      .host_rd    (rsel[OFS_DATA]),
      .host_wdata (hst_wdata),
      .rx_valid   (eng_rx_valid),
      .rx_byte    (eng_rx_byte),
      .tx_ready   (eng_tx_ready),
      .data_q     (data_q),
      .ready_q    (rdy_q)
   );

   always_comb begin
      fl_set           = '0;
      fl_set[FL_BER]   = eng_set_ber;
      fl_set[FL_NACK]  = eng_set_nack;
      fl_set[FL_STALL] = eng_set_stall;
      fl_set[FL_BUSY]  = eng_busy_set;
      fl_clr           = '0;
      fl_clr[FL_BER]   = wsel[OFS_STAT] & hst_wdata[ST_BER];
      fl_clr[FL_NACK]  = wsel[OFS_STAT] & hst_wdata[ST_NACK];
      fl_clr[FL_STALL] = wsel[OFS_STAT] & hst_wdata[ST_STALL];
      fl_clr[FL_BUSY]  = wsel[OFS_CST]  & hst_wdata[CS_BUSY];
   end

   twb_flag_bank #(.NFLAG(FL_N)) i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (fl_set),
      .clr_i  (fl_clr),
      .flag_q (fl_q)
   );

   twb_ctrl_regs #(.DATA_W(DATA_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctl1    (wsel[OFS_CTL1]),
      .wr_own     (wsel[OFS_OWN]),
      .wr_ctl2    (wsel[OFS_CTL2]),
      .wdata      (hst_wdata),
      .start_done (eng_start_done),
      .stop_done  (eng_stop_done),
      .ctl1_vis   (ctl1_vis),
      .own_q      (own_q),
      .ctl2_q     (ctl2_q)
   );

   always_comb begin
      sts_vec           = '0;
      sts_vec[ST_RDY]   = rdy_q;
      sts_vec[ST_BER]   = fl_q[FL_BER];
      sts_vec[ST_NACK]  = fl_q[FL_NACK];
      sts_vec[ST_STALL] = fl_q[FL_STALL];
      sts_vec[ST_MAST]  = eng_master;
      cst_vec           = '0;
      cst_vec[CS_BUSY]  = fl_q[FL_BUSY];
   end

   always_comb begin
      case (hst_addr)
         ADDR_W'(OFS_DATA): hst_rdata = data_q;
         ADDR_W'(OFS_STAT): hst_rdata = sts_vec;
         ADDR_W'(OFS_CST):  hst_rdata = cst_vec;
         ADDR_W'(OFS_CTL1): hst_rdata = ctl1_vis;
         ADDR_W'(OFS_OWN):  hst_rdata = own_q;
         ADDR_W'(OFS_CTL2): hst_rdata = ctl2_q;
         default:           hst_rdata = '0;
      endcase
   end

   assign eng_enable     = ctl2_q[C2_EN];
   assign eng_scl_div    = ctl2_q[DATA_W-1:1];
   assign eng_tx_byte    = data_q;
   assign eng_data_ready = rdy_q;
   assign eng_own_addr   = own_q;
   assign eng_slave_en   = |own_q;
   assign eng_stall_en   = ctl1_vis[C1_STALLE];
   assign eng_int_en     = ctl1_vis[C1_INTE];
   assign eng_ack_ctl    = ctl1_vis[C1_ACK];
   assign eng_start_req  = ctl1_vis[C1_START];
   assign eng_stop_req   = ctl1_vis[C1_STOP];
endmodule

// File: rtl/twb_regfile_chk.sv
module twb_regfile_chk #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_wr,
   input logic [ADDR_W-1:0] hst_addr,
   input logic [DATA_W-1:0] hst_wdata,
   input logic              eng_rx_valid,
   input logic [DATA_W-1:0] eng_rx_byte,
   input logic              eng_set_ber,
   input logic              eng_set_nack,
   input logic              eng_busy_set,
   input logic              eng_start_done,
   input logic              eng_enable,
   input logic [DATA_W-1:0] eng_tx_byte,
   input logic              eng_data_ready,
   input logic              eng_stall_en,
   input logic              eng_int_en,
   input logic              eng_ack_ctl,
   input logic              eng_start_req,
   input logic              eng_stop_req,
   input logic [DATA_W-1:0] sts_vec,
   input logic [DATA_W-1:0] cst_vec
);
   logic st_wr, c1_wr;
   assign st_wr = hst_wr && (hst_addr == ADDR_W'(1));
   assign c1_wr = hst_wr && (hst_addr == ADDR_W'(3));

   p_ber_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && hst_wdata[5] && !eng_set_ber) |=> !sts_vec[5]);

   p_ber_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_set_ber && !st_wr) |=> $stable(sts_vec[5]));

   p_nack_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_set_nack |=> sts_vec[4]);

   p_busy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy_set |=> cst_vec[1]);

   p_ctl1_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_enable) |-> !(eng_stall_en || eng_int_en || eng_ack_ctl ||
                              eng_start_req || eng_stop_req));

   p_start_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start_done && !c1_wr) |=> !eng_start_req);

   p_rx_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rx_valid |=> (eng_data_ready && eng_tx_byte == $past(eng_rx_byte)));
endmodule

bind twb_regfile twb_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .hst_wr         (hst_wr),
   .hst_addr       (hst_addr),
   .hst_wdata      (hst_wdata),
   .eng_rx_valid   (eng_rx_valid),
   .eng_rx_byte    (eng_rx_byte),
   .eng_set_ber    (eng_set_ber),
   .eng_set_nack   (eng_set_nack),
   .eng_busy_set   (eng_busy_set),
   .eng_start_done (eng_start_done),
   .eng_enable     (eng_enable),
   .eng_tx_byte    (eng_tx_byte),
   .eng_data_ready (eng_data_ready),
   .eng_stall_en   (eng_stall_en),
   .eng_int_en     (eng_int_en),
   .eng_ack_ctl    (eng_ack_ctl),
   .eng_start_req  (eng_start_req),
   .eng_stop_req   (eng_stop_req),
   .sts_vec        (sts_vec),
   .cst_vec        (cst_vec)
);

// File: tb/test_twb_regfile.sv
module test_twb_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 3;
   localparam int N_RAND = 4000;
   localparam int WATCHDOG = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_wr = 0, hst_rd = 0;
   logic [2:0] hst_addr = '0;
   logic [7:0] hst_wdata = '0, hst_rdata;
   logic       eng_rx_valid = 0, eng_tx_ready = 0;
   logic [7:0] eng_rx_byte = '0;
   logic       eng_set_ber = 0, eng_set_nack = 0, eng_set_stall = 0;
   logic       eng_master = 0, eng_busy_set = 0;
   logic       eng_start_done = 0, eng_stop_done = 0;
   logic       eng_enable, eng_data_ready, eng_slave_en;
   logic [6:0] eng_scl_div;
   logic [7:0] eng_tx_byte, eng_own_addr;
   logic       eng_stall_en, eng_int_en, eng_ack_ctl, eng_start_req, eng_stop_req;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   // bench model
   logic [7:0] m_data, m_ctl1, m_own, m_ctl2;
   logic       m_rdy, m_ber, m_nack, m_stall, m_busy;

   always #(CLK_PERIOD/2) clk = ~clk;

   twb_regfile #(.ADDR_W(ADDR_W)) i_twb_regfile (.*);

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(logic [2:0] a);
      case (a)
         3'd0: return "R10";
         3'd1: return "R3";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R9";
         3'd5: return "R7";
         default: return "R2";
      endcase
   endfunction

   function automatic logic [7:0] exp_read(logic [2:0] a);
      case (a)
         3'd0: return m_data;
         3'd1: return {1'b0, m_rdy, m_ber, m_nack, m_stall, 1'b0, eng_master, 1'b0};
         3'd2: return {6'b0, m_busy, 1'b0};
         3'd3: return m_ctl2[0] ? m_ctl1 : 8'h00;
         3'd4: return m_own;
         3'd5: return m_ctl2;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_reset();
      m_data = 0; m_ctl1 = 0; m_own = 0; m_ctl2 = 0;
      m_rdy = 0; m_ber = 0; m_nack = 0; m_stall = 0; m_busy = 0;
   endtask

   task automatic model_step();
      logic en, w0, t0, ws, wc;
      en = m_ctl2[0];
      w0 = hst_wr && hst_addr == 0;
      t0 = (hst_wr || hst_rd) && hst_addr == 0;
      ws = hst_wr && hst_addr == 1;
      wc = hst_wr && hst_addr == 2;
      if (eng_rx_valid) m_data = eng_rx_byte;
      else if (w0) m_data = hst_wdata;
      if (eng_rx_valid || eng_tx_ready) m_rdy = 1;
      else if (t0) m_rdy = 0;
      if (eng_set_ber) m_ber = 1; else if (ws && hst_wdata[5]) m_ber = 0;
      if (eng_set_nack) m_nack = 1; else if (ws && hst_wdata[4]) m_nack = 0;
      if (eng_set_stall) m_stall = 1; else if (ws && hst_wdata[3]) m_stall = 0;
      if (eng_busy_set) m_busy = 1; else if (wc && hst_wdata[1]) m_busy = 0;
      if (!en) m_ctl1 = 0;
      else if (hst_wr && hst_addr == 3) m_ctl1 = hst_wdata & 8'hD3;
      else begin
         if (eng_start_done) m_ctl1[0] = 0;
         if (eng_stop_done) m_ctl1[1] = 0;
      end
      if (hst_wr && hst_addr == 4) m_own = hst_wdata;
      if (hst_wr && hst_addr == 5) m_ctl2 = hst_wdata;
   endtask

   task automatic idle_inputs();
      hst_wr = 0; hst_rd = 0;
      eng_rx_valid = 0; eng_tx_ready = 0;
      eng_set_ber = 0; eng_set_nack = 0; eng_set_stall = 0;
      eng_busy_set = 0; eng_start_done = 0; eng_stop_done = 0;
   endtask

   // called at a falling edge with inputs set; returns at the next falling edge
   task automatic tick();
      logic [7:0] c1;
      #1;
      c1 = m_ctl2[0] ? m_ctl1 : 8'h00;
      check8(tag_of(hst_addr), hst_rdata, exp_read(hst_addr));
      check8("R7", {eng_scl_div, eng_enable}, m_ctl2);
      check8("R9", {eng_own_addr[7:1], eng_slave_en ^ (m_own != 0) ^ 1'b1}, {m_own[7:1], 1'b1});
      check8("R10", eng_tx_byte, m_data);
      check8("R11", {7'b0, eng_data_ready}, {7'b0, m_rdy});
      check8("R6", {eng_stall_en, eng_int_en, 1'b0, eng_ack_ctl, 2'b0, eng_stop_req, eng_start_req}, c1);
      @(posedge clk);
      model_step();
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      hst_wr = 1; hst_addr = a; hst_wdata = d;
      tick();
   endtask

   task automatic rd_expect(logic [2:0] a, logic [7:0] e, string tag);
      hst_rd = 1; hst_addr = a;
      #1 check8(tag, hst_rdata, e);
      tick();
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc == WATCHDOG) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_reset();
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      for (int a = 0; a < 8; a++) rd_expect(3'(a), 8'h00, "R1");
      // R12: mastership level visible at once
      eng_master = 1;
      rd_expect(3'd1, 8'h02, "R12");
      eng_master = 0;
      rd_expect(3'd1, 8'h00, "R12");

      // R7: divider readback, still disabled
      wr(3'd5, 8'h70);
      rd_expect(3'd5, 8'h70, "R7");
      // R6: disabled control 1 refuses interrupt enable
      wr(3'd3, 8'h40);
      rd_expect(3'd3, 8'h00, "R6");
      wr(3'd5, 8'h71);
      wr(3'd3, 8'h40);
      rd_expect(3'd3, 8'h40, "R6");
      wr(3'd3, 8'hFF);
      rd_expect(3'd3, 8'hD3, "R6");
      // R6: disabling empties it; re-enable shows zero
      wr(3'd5, 8'h70);
      rd_expect(3'd3, 8'h00, "R6");
      wr(3'd5, 8'h71);
      rd_expect(3'd3, 8'h00, "R6");

      // R8: self-clearing START/STOP
      wr(3'd3, 8'h03);
      eng_start_done = 1;
      rd_expect(3'd3, 8'h03, "R8");
      rd_expect(3'd3, 8'h02, "R8");
      eng_stop_done = 1;
      tick();
      rd_expect(3'd3, 8'h00, "R8");
      eng_start_done = 1;
      wr(3'd3, 8'h01);
      rd_expect(3'd3, 8'h01, "R8");

      // R4 / R3: set beats clear, write 0 keeps, write 1 clears
      eng_set_ber = 1;
      wr(3'd1, 8'h20);
      rd_expect(3'd1, 8'h20, "R4");
      wr(3'd1, 8'h00);
      rd_expect(3'd1, 8'h20, "R3");
      wr(3'd1, 8'h20);
      rd_expect(3'd1, 8'h00, "R3");

      // R5: busy flag
      eng_busy_set = 1;
      tick();
      rd_expect(3'd2, 8'h02, "R5");
      eng_busy_set = 1;
      wr(3'd2, 8'h02);
      rd_expect(3'd2, 8'h02, "R5");
      wr(3'd2, 8'h02);
      rd_expect(3'd2, 8'h00, "R5");

      // R2: unused offsets
      wr(3'd6, 8'hFF);
      wr(3'd7, 8'hFF);
      rd_expect(3'd6, 8'h00, "R2");
      rd_expect(3'd7, 8'h00, "R2");

      // R9: own address
      wr(3'd4, 8'h00);
      check8("R9", {7'b0, eng_slave_en}, 8'h00);
      wr(3'd4, 8'h5A);
      check8("R9", {7'b0, eng_slave_en}, 8'h01);

      // R10 / R11: receive, then read clears ready
      eng_rx_valid = 1; eng_rx_byte = 8'hA5;
      wr(3'd0, 8'h3C);
      rd_expect(3'd1, 8'h40, "R10");
      rd_expect(3'd0, 8'hA5, "R10");
      rd_expect(3'd1, 8'h00, "R11");
      eng_tx_ready = 1;
      tick();
      wr(3'd0, 8'h11);
      rd_expect(3'd1, 8'h00, "R11");

      // constrained random mix
      for (int i = 0; i < N_RAND; i++) begin
         hst_addr       = 3'($urandom_range(0, 7));
         hst_wr         = ($urandom_range(0, 9) < 3);
         hst_rd         = ($urandom_range(0, 9) < 3);
         hst_wdata      = 8'($urandom);
         eng_rx_byte    = 8'($urandom);
         eng_rx_valid   = ($urandom_range(0, 9) == 0);
         eng_tx_ready   = ($urandom_range(0, 9) == 0);
         eng_set_ber    = ($urandom_range(0, 9) == 0);
         eng_set_nack   = ($urandom_range(0, 9) == 0);
         eng_set_stall  = ($urandom_range(0, 9) == 0);
         eng_busy_set   = ($urandom_range(0, 9) == 0);
         eng_start_done = ($urandom_range(0, 5) == 0);
         eng_stop_done  = ($urandom_range(0, 5) == 0);
         eng_master     = 1'($urandom);
         tick();
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule